// File: doc/BRIEF.md
# Two-Wire Clock Control Register Slave

This block is a serial slave on a two-wire bus (clock line and data line, open-drain). It holds a small bank of 8-bit control registers, such as the per-output enable bits of a clock synthesizer. Every register comes out of reset with a known value, so software never has to touch the bus for the chip to work. The bus lets a controller change the registers during system initialization.

The controller reaches the registers with four kinds of transfer: byte write, byte read, block write and block read. The first byte after the address is a command byte. Its top bit chooses between single-byte access and block access. For single-byte access, its low seven bits give the register index. Block transfers carry a byte count after the command and always begin at register zero. They move upward through the registers one byte at a time, until the controller ends the transfer.

Both bus lines are sampled into the system clock domain, and START and STOP are recognised from that sampled view. The data line is modelled as an input plus an active-high pull-low enable.

Top module: `clkreg_smb_slave`

## Requirements
- R1: During and after reset, with no bus activity, register i holds F0h XOR i and the pull-low enable is inactive.
- R2: The slave acknowledges the address byte D2h (7-bit address 69h with the write bit) and D3h (read bit). Any other address byte gets no acknowledge. All further traffic up to the next START then has no effect on the registers and gets no acknowledge.
- R3: Byte write works as follows.
  - A command byte with bit 7 = 1 selects the register given by bits 6:0. Data bytes arrive most-significant bit first.
  - Each byte the slave receives is acknowledged by pulling the data line low during the ninth clock. The pull-low changes only after a falling edge of the bus clock.
  - A register takes its new value when the eighth bit of its data byte is sampled, and at no other time.
  - Further data bytes in the same transfer go to the following indices.
- R4: Byte read works as follows. After a command with bit 7 = 1 and a repeated START with D3h, the slave sends the addressed register most-significant bit first. It changes the data line only while the bus clock is low.
- R5: Block write works as follows.
  - A command byte with bit 7 = 0 selects block mode, whatever its bits 6:0 hold.
  - The next byte is a count. It is acknowledged but stored nowhere.
  - Each following data byte is written to indices 0, 1, 2, … in turn.
  - A STOP after any complete byte leaves all higher registers unchanged.
- R6: Block read works as follows. After a command with bit 7 = 0 and a repeated START with D3h, the slave first sends the number of implemented registers. It then sends register 0, 1, 2, … as long as the controller acknowledges.
- R7: When the controller does not acknowledge a byte the slave sent, the slave releases the data line. It drives nothing more until the next START.
- R8: A write to an index at or above the register count is acknowledged but changes no register. A read of such an index returns 00h.
- R9: START is a high-to-low change of the data line while the clock line is high, and STOP is a low-to-high change under the same condition. Both are judged on the synchronized lines. A START at any bit position restarts byte framing from the address byte. START and STOP both release the data line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin (wired value) |
| sda_drive_low | output | 1 | When high, the pad pulls the data line low |
| regs_o | output | NUM_REGS*8 | Register bank, register i in bits 8*i+7 down to 8*i |

## Verification
The bench builds the slave with six registers, the default address 69h and two synchronizer stages. With only six registers, indices 6, 7 and 9 are out of range. A single byte command can reach them, and a block read runs past the end of the bank within a short transfer. The reference model keeps its own register array and applies each write after the known synchronizer latency. It compares that array with the register outputs on every clock, so an early, late or misdirected write shows up in the cycle it happens.

// File: rtl/clkreg_pkg.sv
package clkreg_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_CMD,
    PH_COUNT,
    PH_WRITE,
    PH_READ
  } phase_t;

  // Reset value of register idx.
  function automatic logic [7:0] reg_default(input int idx);
    return 8'hF0 ^ 8'(idx);
  endfunction

  // True when the upper seven bits of an address byte match the device.
  function automatic logic addr_hit(input logic [7:0] b, input logic [6:0] dev);
    return b[7:1] == dev;
  endfunction

  // First register index selected by a command byte.
  function automatic logic [6:0] cmd_start_index(input logic [7:0] cmd);
    return cmd[7] ? cmd[6:0] : 7'd0;
  endfunction

endpackage

// File: rtl/clkreg_linesync.sv
module clkreg_linesync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_p, sda_p, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_p <= scl_q[STAGES-1];
      sda_p <= sda_q[STAGES-1];
    end
  end

  assign scl_s     = scl_q[STAGES-1];
  assign sda_s     = sda_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/clkreg_bank.sv
module clkreg_bank
  import clkreg_pkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [6:0]            wr_idx,
  input  logic [7:0]            wr_data,
  input  logic [6:0]            rd_idx,
  output logic [7:0]            rd_data,
  output logic [NUM_REGS*8-1:0] regs_flat
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         q <= reg_default(g);
      else if (wr_en && wr_idx == 7'(g))  q <= wr_data;
    end
    assign regs_flat[g*8 +: 8] = q;
  end

  // Indices past the bank read as zero.
  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_idx == 7'(i)) rd_data = regs_flat[i*8 +: 8];
  end
endmodule

// File: rtl/clkreg_xfer.sv
module clkreg_xfer
  import clkreg_pkg::*;
#(
  parameter int         NUM_REGS = 8,
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [7:0] rd_data,
  output logic       sda_low,
  output logic       wr_en,
  output logic [6:0] wr_idx,
  output logic [7:0] wr_data,
  output logic [6:0] rd_idx
);
  localparam logic [7:0] COUNT_BYTE = 8'(NUM_REGS);

  phase_t     phase;
  logic [3:0] bitcnt;      // 0..7 data bits, 8 ack clock, 9 ack done
  logic [6:0] shreg;
  logic       ack_q, tx_live, count_first;
  logic [7:0] tx_q;
  logic [6:0] ptr;

  logic [7:0] rx_byte, tx_next;
  logic [2:0] bit_sel;
  logic       byte_done;

  assign rx_byte   = {shreg, sda_s};
  assign tx_next   = count_first ? COUNT_BYTE : rd_data;
  assign bit_sel   = 3'(4'd7 - bitcnt);
  assign byte_done = scl_rise && (phase != PH_IDLE) && (bitcnt == 4'd7);
  assign wr_en     = byte_done && (phase == PH_WRITE);
  assign wr_idx    = ptr;
  assign wr_data   = rx_byte;
  assign rd_idx    = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase       <= PH_IDLE;
      bitcnt      <= 4'd0;
      shreg       <= 7'd0;
      ack_q       <= 1'b0;
      tx_q        <= 8'd0;
      tx_live     <= 1'b0;
      ptr         <= 7'd0;
      count_first <= 1'b0;
      sda_low     <= 1'b0;
    end else if (start_det) begin
      phase   <= PH_ADDR;
      bitcnt  <= 4'd0;
      ack_q   <= 1'b0;
      tx_live <= 1'b0;
      sda_low <= 1'b0;
    end else if (stop_det) begin
      phase   <= PH_IDLE;
      ack_q   <= 1'b0;
      tx_live <= 1'b0;
      sda_low <= 1'b0;
    end else if (phase != PH_IDLE) begin
      if (scl_rise) begin
        if (bitcnt < 4'd8) begin
          shreg  <= rx_byte[6:0];
          bitcnt <= bitcnt + 4'd1;
          if (bitcnt == 4'd7) begin
            ack_q <= 1'b0;
            unique case (phase)
              PH_ADDR: begin
                if (addr_hit(rx_byte, DEV_ADDR)) begin
                  ack_q <= 1'b1;
                  phase <= rx_byte[0] ? PH_READ : PH_CMD;
                end else begin
                  phase <= PH_IDLE;
                end
              end
              PH_CMD: begin
                ack_q       <= 1'b1;
                ptr         <= cmd_start_index(rx_byte);
                count_first <= ~rx_byte[7];
                phase       <= rx_byte[7] ? PH_WRITE : PH_COUNT;
              end
              PH_COUNT: begin
                ack_q <= 1'b1;
                phase <= PH_WRITE;
              end
              PH_WRITE: begin
                ack_q <= 1'b1;
                ptr   <= ptr + 7'd1;
              end
              default: ;
            endcase
          end
        end else if (bitcnt == 4'd8) begin
          bitcnt <= 4'd9;
          if (phase == PH_READ && tx_live) begin
            if (sda_s)            phase       <= PH_IDLE;   // master NACK
            else if (count_first) count_first <= 1'b0;
            else                  ptr         <= ptr + 7'd1;
          end
        end
      end else if (scl_fall) begin
        if (bitcnt == 4'd8) begin
          sda_low <= ack_q;
        end else if (bitcnt == 4'd9) begin
          bitcnt <= 4'd0;
          ack_q  <= 1'b0;
          if (phase == PH_READ) begin
            tx_q    <= tx_next;
            tx_live <= 1'b1;
            sda_low <= ~tx_next[7];
          end else begin
            sda_low <= 1'b0;
          end
        end else if (phase == PH_READ && tx_live && bitcnt != 4'd0) begin
          sda_low <= ~tx_q[bit_sel];
        end
      end
    end
  end
endmodule

// File: rtl/clkreg_smb_slave.sv
module clkreg_smb_slave #(
  parameter int         NUM_REGS    = 8,
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_drive_low,
  output logic [NUM_REGS*8-1:0] regs_o
);
  localparam int REG_BITS = NUM_REGS * 8;

  logic       sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic       wr_en;
  logic [6:0] wr_idx, rd_idx;
  logic [7:0] wr_data, rd_data;
  logic [REG_BITS-1:0] bank_bits;

  clkreg_linesync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  clkreg_xfer #(.NUM_REGS(NUM_REGS), .DEV_ADDR(DEV_ADDR)) u_xfer (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .rd_data(rd_data), .sda_low(sda_drive_low), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_data(wr_data), .rd_idx(rd_idx)
  );

  clkreg_bank #(.NUM_REGS(NUM_REGS)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data),
    .regs_flat(bank_bits)
  );

  assign regs_o = bank_bits;
endmodule

// File: rtl/clkreg_smb_checker.sv
module clkreg_smb_checker #(
  parameter int NUM_REGS = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  scl_rise,
  input logic                  scl_fall,
  input logic                  start_det,
  input logic                  stop_det,
  input logic                  wr_en,
  input logic [6:0]            wr_idx,
  input logic                  sda_drive_low,
  input logic [NUM_REGS*8-1:0] regs_o
);
  AST_PULL_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_drive_low) |-> $past(scl_fall)); // R3

  AST_WRITE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs_o) |-> $past(wr_en)); // R3

  AST_FAR_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx >= 7'(NUM_REGS)) |=> $stable(regs_o)); // R8

  AST_BUS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det || stop_det) |=> !sda_drive_low); // R9

  AST_EVENT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_det, stop_det, scl_rise, scl_fall})); // R9
endmodule

bind clkreg_smb_slave clkreg_smb_checker #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
  .start_det(start_det), .stop_det(stop_det), .wr_en(wr_en),
  .wr_idx(wr_idx), .sda_drive_low(sda_drive_low), .regs_o(regs_o)
);

// File: tb/clkreg_smb_slave_test.sv
module clkreg_smb_slave_test;
  localparam int CLK_PERIOD = 10;
  localparam int NUM        = 6;
  localparam int HALF       = 8;   // system clocks per bus clock phase
  localparam int LAT        = 4;   // negedges from SCL rise drive to register update

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, msda = 1'b1;
  logic drv;
  logic [NUM*8-1:0] regs;
  wire  sda_line = msda & ~drv;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkreg_smb_slave #(.NUM_REGS(NUM), .DEV_ADDR(7'h69), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_drive_low(drv), .regs_o(regs)
  );

  int checks = 0, fails = 0;
  logic [7:0] model [NUM];
  int pend_cd = 0, pend_idx = 0;
  logic [7:0] pend_val = 8'h00;
  bit done = 1'b0;

  function automatic logic [7:0] dflt(int i);
    return 8'(240 + i);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Reference register mirror, compared on every clock.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (pend_cd > 0) begin
        pend_cd--;
        if (pend_cd == 0 && pend_idx < NUM) model[pend_idx] = pend_val;
      end
      checks++;
      for (int i = 0; i < NUM; i++) begin
        if (regs[i*8 +: 8] !== model[i]) begin
          fails++;
          $display("FAIL R3/R5 mirror idx=%0d actual=%0h expected=%0h", i, regs[i*8 +: 8], model[i]);
          break;
        end
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic bus_start();
    msda = 1'b1; cyc(HALF);
    scl = 1'b1;  cyc(HALF);
    msda = 1'b0; cyc(HALF);
    scl = 1'b0;  cyc(2);
  endtask

  task automatic bus_stop();
    msda = 1'b0; cyc(HALF);
    scl = 1'b1;  cyc(HALF);
    msda = 1'b1; cyc(HALF);
  endtask

  task automatic write_byte(logic [7:0] b, bit exp_ack, bit commit, int idx, string req);
    for (int i = 7; i >= 0; i--) begin
      msda = b[i]; cyc(HALF);
      scl = 1'b1;
      if (i == 0 && commit) begin
        pend_idx = idx; pend_val = b; pend_cd = LAT;
      end
      cyc(HALF);
      scl = 1'b0; cyc(2);
    end
    msda = 1'b1; cyc(HALF);
    scl = 1'b1;  cyc(HALF/2);
    check((sda_line == 1'b0) == exp_ack, req, "ack", int'(sda_line), int'(!exp_ack));
    cyc(HALF/2);
    scl = 1'b0; cyc(2);
  endtask

  task automatic read_byte(logic [7:0] exp, bit mack, string req);
    logic [7:0] got;
    got = 8'h00;
    msda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      cyc(HALF);
      scl = 1'b1; cyc(HALF/2);
      got[i] = sda_line;
      cyc(HALF/2);
      scl = 1'b0; cyc(2);
    end
    msda = !mack; cyc(HALF);
    scl = 1'b1;   cyc(HALF);
    scl = 1'b0;   cyc(2);
    msda = 1'b1;
    check(got == exp, req, "read data", int'(got), int'(exp));
  endtask

  task automatic byte_read(logic [6:0] idx, logic [7:0] exp, string req);
    bus_start();
    write_byte(8'hD2, 1'b1, 1'b0, 0, "R2");
    write_byte({1'b1, idx}, 1'b1, 1'b0, 0, req);
    bus_start();
    write_byte(8'hD3, 1'b1, 1'b0, 0, "R2");
    read_byte(exp, 1'b0, req);
    bus_stop();
  endtask

  initial begin
    logic [NUM*8-1:0] snap;
    for (int i = 0; i < NUM; i++) model[i] = dflt(i);
    cyc(5);
    // R1: reset state
    check(drv == 1'b0, "R1", "pull-low in reset", int'(drv), 0);
    for (int i = 0; i < NUM; i++)
      check(regs[i*8 +: 8] == dflt(i), "R1", "reset value", int'(regs[i*8 +: 8]), int'(dflt(i)));
    rst_n = 1'b1;
    cyc(5);

    // R2 R3: byte write index 2
    bus_start();
    write_byte(8'hD2, 1'b1, 1'b0, 0, "R2");
    write_byte(8'h82, 1'b1, 1'b0, 0, "R3");
    write_byte(8'h5A, 1'b1, 1'b1, 2, "R3");
    bus_stop();
    check(regs[2*8 +: 8] == 8'h5A, "R3", "byte write", int'(regs[2*8 +: 8]), 8'h5A);

    // R4: byte reads of written and default registers
    byte_read(7'd2, 8'h5A, "R4");
    byte_read(7'd4, dflt(4), "R4");

    // R2: foreign address ignored
    bus_start();
    write_byte(8'hA0, 1'b0, 1'b0, 0, "R2");
    write_byte(8'h81, 1'b0, 1'b0, 0, "R2");
    write_byte(8'h00, 1'b0, 1'b0, 0, "R2");
    bus_stop();
    check(regs[1*8 +: 8] == dflt(1), "R2", "foreign write ignored", int'(regs[1*8 +: 8]), int'(dflt(1)));

    // R5: block write, command bits 6:0 nonzero, stopped after three data bytes
    bus_start();
    write_byte(8'hD2, 1'b1, 1'b0, 0, "R2");
    write_byte(8'h05, 1'b1, 1'b0, 0, "R5");
    write_byte(8'h04, 1'b1, 1'b0, 0, "R5");
    write_byte(8'h11, 1'b1, 1'b1, 0, "R5");
    write_byte(8'h22, 1'b1, 1'b1, 1, "R5");
    write_byte(8'h33, 1'b1, 1'b1, 2, "R5");
    bus_stop();
    check(regs[0 +: 8] == 8'h11, "R5", "block byte 0", int'(regs[0 +: 8]), 8'h11);
    check(regs[3*8 +: 8] == dflt(3), "R5", "untouched after stop", int'(regs[3*8 +: 8]), int'(dflt(3)));

    // R6 R8: block read with count, then past the end
    bus_start();
    write_byte(8'hD2, 1'b1, 1'b0, 0, "R2");
    write_byte(8'h00, 1'b1, 1'b0, 0, "R6");
    bus_start();
    write_byte(8'hD3, 1'b1, 1'b0, 0, "R2");
    read_byte(8'(NUM), 1'b1, "R6");
    for (int i = 0; i < NUM; i++) read_byte(model[i], 1'b1, "R6");
    read_byte(8'h00, 1'b0, "R8");
    bus_stop();

    // R8: out-of-range write acknowledged and discarded; out-of-range read
    snap = regs;
    bus_start();
    write_byte(8'hD2, 1'b1, 1'b0, 0, "R2");
    write_byte(8'h87, 1'b1, 1'b0, 0, "R8");
    write_byte(8'h99, 1'b1, 1'b1, 7, "R8");
    bus_stop();
    check(regs == snap, "R8", "bank after far write", int'(regs[31:0]), int'(snap[31:0]));
    byte_read(7'd9, 8'h00, "R8");

    // R3: byte mode continues at the next index
    bus_start();
    write_byte(8'hD2, 1'b1, 1'b0, 0, "R2");
    write_byte(8'h84, 1'b1, 1'b0, 0, "R3");
    write_byte(8'hC1, 1'b1, 1'b1, 4, "R3");
    write_byte(8'hC2, 1'b1, 1'b1, 5, "R3");
    bus_stop();
    byte_read(7'd5, 8'hC2, "R3");

    // R7: after master NACK the slave drives nothing
    bus_start();
    write_byte(8'hD2, 1'b1, 1'b0, 0, "R2");
    write_byte(8'h80, 1'b1, 1'b0, 0, "R4");
    bus_start();
    write_byte(8'hD3, 1'b1, 1'b0, 0, "R2");
    read_byte(model[0], 1'b0, "R7");
    read_byte(8'hFF, 1'b1, "R7");
    check(drv == 1'b0, "R7", "released after nack", int'(drv), 0);
    bus_stop();

    // R9: START in mid-byte restarts framing
    bus_start();
    write_byte(8'hD2, 1'b1, 1'b0, 0, "R2");
    for (int i = 0; i < 4; i++) begin
      msda = i[0]; cyc(HALF);
      scl = 1'b1;  cyc(HALF);
      scl = 1'b0;  cyc(2);
    end
    bus_start();
    write_byte(8'hD2, 1'b1, 1'b0, 0, "R9");
    write_byte(8'h83, 1'b1, 1'b0, 0, "R9");
    write_byte(8'h77, 1'b1, 1'b1, 3, "R9");
    bus_stop();
    check(regs[3*8 +: 8] == 8'h77, "R9", "write after restart", int'(regs[3*8 +: 8]), 8'h77);
    check(drv == 1'b0, "R9", "released after stop", int'(drv), 0);

    cyc(10);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule